// File: doc/BRIEF.md
# Rational Sample Strobe Generator

This block turns a fast reference clock into a one-cycle sample strobe whose average spacing is a rational number of clock cycles, N/(M+1). The strobe paces an audio sample FIFO and acts as the audio-side sync. Because the spacing is usually not a whole number of cycles, no plain divide counter is used. An error accumulator adds the denominator every cycle and gives up N each time it fires, so the fractional part carries over from one sample to the next and never drifts.

Software packs N and M into one 32-bit configuration word. It chooses them so that N/(M+1) approximates the reference frequency divided by the sample rate; typical sample rates run from 32 kHz to 192 kHz. Any write to the word restarts the timing from a clean phase. An enable input gates the whole generator.

Top module: `rate_strobe_gen`

## Requirements
- R1: Reset drives `strobe` low, clears the accumulator and loads the configuration N=1, M=0. With that configuration, an enabled block strobes on every cycle.
- R2: In `cfgData`, N is taken from bits 31:8 (24 bits) and M from bits 7:0. The denominator used is M+1, which ranges from 1 to 256.
- R3: When N >= M+1, counting from a restart, `strobe` is high in the k-th enabled cycle exactly when floor(k*(M+1)/N) exceeds floor((k-1)*(M+1)/N). Over time the average spacing is therefore N/(M+1) cycles.
- R4: When M+1 divides N, strobes are spaced exactly N/(M+1) cycles apart, and the first one falls on the N/(M+1)-th enabled cycle after a restart.
- R5: A cycle with `cfgWrite` high stores `cfgData`, clears the accumulator and leaves `strobe` low in the following cycle, whether or not `enable` is high. Timing then restarts at phase zero.
- R6: While `enable` is low, no strobe is produced and the accumulator is held at zero. Raising `enable` again restarts timing at phase zero.
- R7: When N < M+1 (N=0 included), an enabled block that is not being written holds `strobe` high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator while high |
| cfgWrite | input | 1 | One-cycle write strobe for the configuration word |
| cfgData | input | 32 | Configuration word: N in 31:8, M in 7:0 |
| strobe | output | 1 | Registered sample strobe |

## Verification
The checker watches several properties on every cycle. The accumulator never reaches N in the non-saturated case. A configuration write or a low enable always leaves the strobe low in the next cycle, and a disabled block keeps its accumulator at zero. In the saturated case the strobe stays high. The exact placement of each strobe can only be shown by the bench scenarios: the floor-based pattern, the phase restart after a rewrite or a re-enable, the reset configuration, and the field positions. The bench compares every cycle against a reference computed from N and M.

// File: rtl/rate_strobe_pkg.sv
package rate_strobe_pkg;
  // control-to-datapath strobes, one set per cycle
  typedef struct packed {
    logic clearAcc;  // zero the accumulator, force strobe low
    logic advance;   // add the denominator this cycle
    logic saturate;  // N below denominator: strobe every cycle
  } strobe_ctrl_t;
endpackage

// File: rtl/rate_strobe_ctrl.sv
module rate_strobe_ctrl
  import rate_strobe_pkg::*;
#(
  parameter int N_WIDTH = 24,
  parameter int M_WIDTH = 8,
  parameter int RESET_N = 1,
  parameter int RESET_M = 0,
  localparam int CFG_W = N_WIDTH + M_WIDTH,
  localparam int DEN_W = M_WIDTH + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWrite,
  input  logic [CFG_W-1:0]   cfgData,
  output strobe_ctrl_t       ctrlBus,
  output logic [N_WIDTH-1:0] nVal,
  output logic [DEN_W-1:0]   denom
);
  localparam logic [CFG_W-1:0] CFG_RESET =
    {N_WIDTH'(RESET_N), M_WIDTH'(RESET_M)};

  logic [CFG_W-1:0]   cfgReg;
  logic [M_WIDTH-1:0] mVal;

  always_ff @(posedge clk) begin
    if (!rstN)         cfgReg <= CFG_RESET;
    else if (cfgWrite) cfgReg <= cfgData;
  end

  assign nVal  = cfgReg[CFG_W-1:M_WIDTH];
  assign mVal  = cfgReg[M_WIDTH-1:0];
  assign denom = DEN_W'(mVal) + DEN_W'(1);

  always_comb begin
    ctrlBus.clearAcc = cfgWrite | ~enable;
    ctrlBus.advance  = enable & ~cfgWrite;
    ctrlBus.saturate = (N_WIDTH + 1)'(nVal) < (N_WIDTH + 1)'(denom);
  end
endmodule

// File: rtl/rate_strobe_dp.sv
module rate_strobe_dp
  import rate_strobe_pkg::*;
#(
  parameter int N_WIDTH = 24,
  parameter int M_WIDTH = 8,
  localparam int DEN_W = M_WIDTH + 1,
  localparam int ACC_W = N_WIDTH + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_ctrl_t       ctrlBus,
  input  logic [N_WIDTH-1:0] nVal,
  input  logic [DEN_W-1:0]   denom,
  output logic [ACC_W-1:0]   accVal,
  output logic               strobe
);
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] nExt;
  logic             hit;

  assign nExt = ACC_W'(nVal);
  assign sum  = accVal + ACC_W'(denom);
  assign hit  = sum >= nExt;

  always_ff @(posedge clk) begin
    if (!rstN || ctrlBus.clearAcc) begin
      accVal <= '0;
      strobe <= 1'b0;
    end else if (ctrlBus.saturate) begin
      accVal <= '0;
      strobe <= 1'b1;
    end else if (ctrlBus.advance) begin
      accVal <= hit ? (sum - nExt) : sum;
      strobe <= hit;
    end else begin
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rate_strobe_pkg::*;
#(
  parameter int N_WIDTH = 24,
  parameter int M_WIDTH = 8,
  parameter int RESET_N = 1,
  parameter int RESET_M = 0,
  localparam int CFG_W = N_WIDTH + M_WIDTH,
  localparam int DEN_W = M_WIDTH + 1,
  localparam int ACC_W = N_WIDTH + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgData,
  output logic             strobe
);
  strobe_ctrl_t       ctrlBus;
  logic [N_WIDTH-1:0] nVal;
  logic [DEN_W-1:0]   denom;
  logic [ACC_W-1:0]   accVal;

  rate_strobe_ctrl #(
    .N_WIDTH(N_WIDTH), .M_WIDTH(M_WIDTH),
    .RESET_N(RESET_N), .RESET_M(RESET_M)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgData(cfgData), .ctrlBus(ctrlBus), .nVal(nVal), .denom(denom)
  );

  rate_strobe_dp #(.N_WIDTH(N_WIDTH), .M_WIDTH(M_WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .nVal(nVal),
    .denom(denom), .accVal(accVal), .strobe(strobe)
  );
endmodule

// File: rtl/rate_strobe_chk.sv
module rate_strobe_chk #(
  parameter int N_WIDTH = 24,
  localparam int ACC_W = N_WIDTH + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               cfgWrite,
  input logic               strobe,
  input logic               saturate,
  input logic [ACC_W-1:0]   acc,
  input logic [N_WIDTH-1:0] nVal
);
  assert_acc_below_n_R3: assert property (@(posedge clk) disable iff (!rstN)
    !saturate |-> (acc < ACC_W'(nVal)));

  assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrite |=> !strobe);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!strobe && acc == '0));

  assert_saturated_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (saturate && enable && !cfgWrite) |=> strobe);
endmodule

bind rate_strobe_gen rate_strobe_chk #(.N_WIDTH(N_WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
  .strobe(strobe), .saturate(ctrlBus.saturate), .acc(accVal), .nVal(nVal)
);

// File: tb/rate_strobe_gen_tb.sv
module rate_strobe_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] cfgData = '0;
  logic        strobe;

  int total = 0;
  int bad = 0;
  int cycleCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  rate_strobe_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrite(cfgWrite),
    .cfgData(cfgData), .strobe(strobe)
  );

  // {N[23:0], M[7:0], cycles[15:0]}
  localparam int NVEC = 10;
  localparam logic [47:0] VECS [NVEC] = '{
    {24'd3,        8'd0,   16'd40},
    {24'd3,        8'd1,   16'd40},
    {24'd10,       8'd2,   16'd60},
    {24'd48,       8'd0,   16'd150},
    {24'd12,       8'd3,   16'd40},
    {24'd7,        8'd6,   16'd20},
    {24'd1000,     8'd255, 16'd80},
    {24'd5,        8'd9,   16'd20},
    {24'd0,        8'd0,   16'd20},
    {24'hFFFFFF,   8'd255, 16'd300}
  };

  function automatic bit expStrobe(longint unsigned n, longint unsigned d,
                                   longint unsigned k);
    if (n < d) return 1'b1;
    return ((k * d) / n) != (((k - 1) * d) / n);
  endfunction

  task automatic check(bit actual, bit expected, string tag);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s: strobe=%0b expected=%0b at cycle %0d",
               tag, actual, expected, cycleCount);
    end
  endtask

  task automatic writeCfg(logic [23:0] n, logic [7:0] m);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgData  = {n, m};
    @(negedge clk);
    cfgWrite = 1'b0;
    check(strobe, 1'b0, "R5 quiet after write");
  endtask

  // run k=1..len enabled cycles and compare against the floor model
  task automatic runModel(int unsigned n, int unsigned d, int len, string tag);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      check(strobe, expStrobe(n, d, k), tag);
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(strobe, 1'b0, "R1 strobe low in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(strobe, 1'b0, "R1 low after reset, disabled");
    enable = 1'b1;
    runModel(1, 1, 5, "R1 reset config N=1 M=0");

    // vector table: R2 field positions, R3/R4 spacing, R7 saturation
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] n;
      logic [7:0]  m;
      logic [15:0] len;
      {n, m, len} = VECS[v];
      writeCfg(n, m);
      runModel(n, m + 1, len, (n < m + 1) ? "R7 saturated" : "R2/R3/R4 spacing");
    end

    // R4: first strobe lands on cycle N/(M+1) exactly
    writeCfg(24'd20, 8'd4);
    runModel(20, 5, 3, "R4 no early strobe");
    @(negedge clk);
    check(strobe, 1'b1, "R4 first strobe at cycle 4");

    // R5: rewrite mid-stream restarts the phase
    writeCfg(24'd5, 8'd0);
    runModel(5, 1, 3, "R5 before rewrite");
    writeCfg(24'd5, 8'd0);
    runModel(5, 1, 12, "R5 restart after rewrite");

    // R5: write while disabled still restarts cleanly
    enable = 1'b0;
    writeCfg(24'd4, 8'd1);
    @(negedge clk);
    enable = 1'b1;
    runModel(4, 2, 10, "R5 write while disabled");

    // R6: disable holds strobe low, re-enable restarts phase
    writeCfg(24'd4, 8'd0);
    runModel(4, 1, 2, "R6 before disable");
    enable = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(strobe, 1'b0, "R6 disabled");
    end
    enable = 1'b1;
    runModel(4, 1, 12, "R6 restart after enable");

    // R6: saturated config still silent while disabled
    writeCfg(24'd0, 8'd3);
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(strobe, 1'b0, "R6 saturated but disabled");
    end
    enable = 1'b1;
    runModel(0, 4, 4, "R7 saturated after enable");

    // R1: reset mid-run restores the reset configuration
    writeCfg(24'd9, 8'd0);
    runModel(9, 1, 3, "R1 pre-reset run");
    rstN = 1'b0;
    @(negedge clk);
    check(strobe, 1'b0, "R1 strobe low in reset");
    rstN = 1'b1;
    runModel(1, 1, 4, "R1 reset config restored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule